// File: doc/BRIEF.md
# Warp memory access coalescer

The block sits between a warp's load/store issue stage and the memory pipeline. It takes one memory instruction for a whole warp: an active-thread mask and one byte address per lane. Every address is reduced to its cache line. Active lanes that land in the same line share one line request. The distinct lines then go out on a valid/ready request port, one line per cycle at most. The order follows the lowest lane that touches each line.

When the last line request of an instruction is accepted, the block pulses a completion output. For the instruction just taken, it reports how many line requests were produced and whether that number exceeds one (uncoalesced). Three saturating running counters total the instructions, the line requests and the uncoalesced instructions, so that coalescing efficiency can be averaged.

A mode input selects how extra lines are paid for. In penalty mode, one dead cycle is inserted after every accepted request that is not the last of its instruction. In streaming mode, the lines go out back to back.

Top module: `warp_coalescer`

## Requirements
- R1: The line of a lane is its byte address with the low log2(LINE_BYTES) bits cleared (LINE_BYTES = 128, so bits [6:0]). All active lanes whose addresses share a line produce exactly one request, and `req_line` carries that cleared line address.
- R2: A lane whose `in_mask` bit is 0 contributes no request. An instruction with an all-zero mask raises `done` in the cycle after acceptance, with `line_count` = 0, `busy` low and no request issued.
- R3: Distinct lines are issued in ascending order of the lowest active lane index that references each line, whatever the numeric order of the addresses.
- R4: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high and `req_line` unchanged.
- R5: An instruction is accepted at a clock edge where `in_valid` is high and `busy` is low. `busy` is high from the cycle after a non-empty instruction is accepted through the cycle of its last handshake. `in_valid` has no effect while `busy` is high.
- R6: `done` is a single-cycle pulse in the cycle after the handshake of an instruction's last line, and is low otherwise (except for the empty-mask case of R2).
- R7: From the cycle after acceptance until the next acceptance, `line_count` holds the number of distinct lines of the instruction, and `uncoalesced` is 1 exactly when that number is greater than one.
- R8: With `stream_mode` = 0 (penalty mode), `req_valid` is low for exactly one cycle after every handshake that leaves lines pending.
- R9: With `stream_mode` = 1, `req_valid` is high in every cycle from the cycle after acceptance until the last handshake.
- R10: `stat_instr`, `stat_lines` and `stat_uncoal` advance at each acceptance by 1, by the line count, and by 1 when uncoalesced. Each stops at its all-ones value and never decreases.
- R11: After reset, `busy`, `req_valid`, `done`, `line_count`, `uncoalesced` and all three counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stream_mode | input | 1 | 1 = issue lines back to back, 0 = one dead cycle between lines |
| in_valid | input | 1 | Instruction offered |
| in_mask | input | LANES | Active-lane mask, bit i = lane i |
| in_addr | input | LANES*ADDR_W | Byte address of lane i at bits [i*ADDR_W +: ADDR_W] |
| busy | output | 1 | Lines of the current instruction still pending |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_line | output | ADDR_W | Line-aligned request address |
| done | output | 1 | Instruction finished issuing |
| line_count | output | $clog2(LANES+1) | Distinct lines of the last accepted instruction |
| uncoalesced | output | 1 | Last accepted instruction needed more than one line |
| stat_instr | output | CNT_W | Saturating instruction total |
| stat_lines | output | CNT_W | Saturating line-request total |
| stat_uncoal | output | CNT_W | Saturating uncoalesced-instruction total |

## Verification
The bench keeps the full 32 lanes and a 128-byte line, so warps from one line up to 32 lines occur, in both issue modes. It narrows CNT_W to 6, so all three running totals reach their all-ones value within a few hundred instructions. This makes the saturation behaviour observable. Random `req_ready` back-pressure and junk instructions offered while busy exercise the hold and ignore rules against a lane-order reference list.

// File: rtl/coal_pkg.sv
// Shared definitions for the warp coalescer.
// Assumes: nothing beyond SystemVerilog 2017.
package coal_pkg;

    // Issue discipline for the extra lines of an uncoalesced instruction.
    typedef enum logic [0:0] {
        MODE_PENALTY = 1'b0,
        MODE_STREAM  = 1'b1
    } issue_mode_e;

endpackage

// File: rtl/coal_line_map.sv
// Per-lane line extraction and duplicate folding.
// Purely combinational. A lane is a "leader" when it is active and no
// lower-numbered active lane maps to the same line. The leader count is the
// number of requests the instruction will need.
// Assumes: OFF_W < ADDR_W.
module coal_line_map #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 7,
    localparam int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*ADDR_W-1:0] addr,
    output logic [LANES*ADDR_W-1:0] lines,
    output logic [LANES-1:0]        leader,
    output logic [CW-1:0]           count
);

    logic [ADDR_W-1:0] line_a [LANES];

    // Clear the in-line offset of every lane address.
    for (genvar g = 0; g < LANES; g++) begin : g_line
        assign line_a[g] = {addr[g*ADDR_W+OFF_W +: ADDR_W-OFF_W], {OFF_W{1'b0}}};
        assign lines[g*ADDR_W +: ADDR_W] = line_a[g];
    end

    // Mark lanes whose line was not already claimed by a lower active lane.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic dup;
            dup = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (mask[j] && (line_a[j] == line_a[i])) dup = 1'b1;
            end
            leader[i] = mask[i] && !dup;
        end
    end

    // Count the leaders.
    always_comb begin
        count = '0;
        for (int i = 0; i < LANES; i++) count = count + CW'(leader[i]);
    end

endmodule

// File: rtl/coal_lowest_pick.sv
// Lowest-set-bit selector over the pending line mask.
// Gives the index and one-hot of the lowest pending lane, and whether it is
// the only pending one. Assumes LANES >= 2.
module coal_lowest_pick #(
    parameter int LANES = 32,
    localparam int IW   = $clog2(LANES)
) (
    input  logic [LANES-1:0] vec,
    output logic [LANES-1:0] onehot,
    output logic [IW-1:0]    idx,
    output logic             last
);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // Isolate the lowest set bit and detect a single remaining bit.
    always_comb begin
        onehot = vec & (~vec + LANES'(1));
        last   = (vec != '0) && ((vec & (vec - LANES'(1))) == '0);
    end

    // R3: at most one lane is selected at a time.
    always_comb begin
        a_r3_single_pick: assert ($onehot0(onehot));
    end

endmodule

// File: rtl/coal_stats.sv
// Saturating running totals of instructions, line requests and
// uncoalesced instructions. Advances once per accepted instruction.
// Assumes: CNT_W >= CW.
module coal_stats #(
    parameter int CNT_W = 32,
    parameter int CW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [CW-1:0]    nlines,
    output logic [CNT_W-1:0] tot_instr,
    output logic [CNT_W-1:0] tot_lines,
    output logic [CNT_W-1:0] tot_uncoal
);

    localparam logic [CNT_W-1:0] SAT = '1;

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W] ? SAT : s[CNT_W-1:0];
    endfunction

    // Fold each accepted instruction into the three totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_instr  <= '0;
            tot_lines  <= '0;
            tot_uncoal <= '0;
        end else if (evt) begin
            tot_instr  <= sat_add(tot_instr, CNT_W'(1));
            tot_lines  <= sat_add(tot_lines, CNT_W'(nlines));
            tot_uncoal <= sat_add(tot_uncoal, CNT_W'(nlines > CW'(1)));
        end
    end

    a_r10_instr_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tot_instr >= $past(tot_instr));
    a_r10_lines_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tot_lines >= $past(tot_lines));
    a_r10_uncoal_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tot_uncoal <= tot_instr);

endmodule

// File: rtl/warp_coalescer.sv
// Warp memory access coalescer.
// Accepts one warp instruction (mask plus per-lane byte address) when idle,
// folds lanes that share a cache line, and issues each distinct line on a
// valid/ready port in lowest-lane order. In penalty mode a dead cycle
// follows every non-final handshake; in stream mode lines go back to back.
// Assumes: LINE_BYTES is a power of two, LANES >= 2.
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int CNT_W      = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CW        = $clog2(LANES + 1),
    localparam int IW        = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stream_mode,
    input  logic                    in_valid,
    input  logic [LANES-1:0]        in_mask,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    output logic                    busy,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [ADDR_W-1:0]       req_line,
    output logic                    done,
    output logic [CW-1:0]           line_count,
    output logic                    uncoalesced,
    output logic [CNT_W-1:0]        stat_instr,
    output logic [CNT_W-1:0]        stat_lines,
    output logic [CNT_W-1:0]        stat_uncoal
);

    logic [LANES*ADDR_W-1:0] map_lines;
    logic [LANES-1:0]        map_leader;
    logic [CW-1:0]           map_count;

    logic [ADDR_W-1:0] lines_q [LANES];
    logic [LANES-1:0]  pend_q;
    logic              gap_q;
    logic              done_q;
    logic [CW-1:0]     cnt_q;
    logic              unc_q;

    logic [LANES-1:0] pick_oh;
    logic [IW-1:0]    pick_idx;
    logic             pick_last;
    logic             accept;
    logic             handshake;
    issue_mode_e      mode;

    coal_line_map #(
        .LANES (LANES),
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W)
    ) u_map (
        .mask  (in_mask),
        .addr  (in_addr),
        .lines (map_lines),
        .leader(map_leader),
        .count (map_count)
    );

    coal_lowest_pick #(
        .LANES(LANES)
    ) u_pick (
        .vec   (pend_q),
        .onehot(pick_oh),
        .idx   (pick_idx),
        .last  (pick_last)
    );

    coal_stats #(
        .CNT_W(CNT_W),
        .CW   (CW)
    ) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (accept),
        .nlines    (map_count),
        .tot_instr (stat_instr),
        .tot_lines (stat_lines),
        .tot_uncoal(stat_uncoal)
    );

    // Handshake and mode decode.
    always_comb begin
        mode      = issue_mode_e'(stream_mode);
        busy      = (pend_q != '0);
        accept    = in_valid && !busy;
        req_valid = busy && !gap_q;
        handshake = req_valid && req_ready;
        req_line  = lines_q[pick_idx];
    end

    // Line address store; data path, written only on acceptance.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < LANES; i++) lines_q[i] <= map_lines[i*ADDR_W +: ADDR_W];
        end
    end

    // Pending mask, issue spacing, completion pulse and per-instruction report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            gap_q  <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            unc_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            gap_q  <= 1'b0;
            if (accept) begin
                pend_q <= map_leader;
                cnt_q  <= map_count;
                unc_q  <= (map_count > CW'(1));
                done_q <= (map_count == '0);
            end else if (handshake) begin
                pend_q <= pend_q & ~pick_oh;
                done_q <= pick_last;
                gap_q  <= !pick_last && (mode == MODE_PENALTY);
            end
        end
    end

    assign done        = done_q;
    assign line_count  = cnt_q;
    assign uncoalesced = unc_q;

    a_r4_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_line));
    a_r8_penalty_gap: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !stream_mode |=> !req_valid);
    a_r5_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && in_valid |=> $stable(line_count) && $stable(stat_instr));
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !req_valid);
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done || $past(in_valid));
    a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_line[OFF_W-1:0] == '0);

endmodule

// File: tb/warp_coalescer_bench.sv
// Self-checking bench for warp_coalescer: directed corners plus seeded
// random warps, compared against a lane-order reference list.
module warp_coalescer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 32;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 128;
    localparam int CNT_W      = 6;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int CW         = $clog2(LANES + 1);
    localparam longint SAT    = (64'd1 << CNT_W) - 1;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stream_mode = 1'b0;
    logic in_valid = 1'b0;
    logic [LANES-1:0] in_mask = '0;
    logic [LANES*ADDR_W-1:0] in_addr;
    logic busy, req_valid, done, uncoalesced;
    logic req_ready = 1'b0;
    logic [ADDR_W-1:0] req_line;
    logic [CW-1:0] line_count;
    logic [CNT_W-1:0] stat_instr, stat_lines, stat_uncoal;

    logic [ADDR_W-1:0] addr_a [LANES];
    logic [ADDR_W-1:0] exp_l [LANES];
    int exp_n;
    longint m_instr = 0, m_lines = 0, m_unc = 0;
    int n_checks = 0, n_fails = 0;
    int cycles = 0;
    bit finished = 0;

    warp_coalescer #(
        .LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)
    ) u_warp_coalescer (
        .clk(clk), .rst_n(rst_n), .stream_mode(stream_mode),
        .in_valid(in_valid), .in_mask(in_mask), .in_addr(in_addr),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_line(req_line), .done(done), .line_count(line_count),
        .uncoalesced(uncoalesced), .stat_instr(stat_instr),
        .stat_lines(stat_lines), .stat_uncoal(stat_uncoal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < LANES; i++) in_addr[i*ADDR_W +: ADDR_W] = addr_a[i];
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic longint sat(input longint v);
        return (v > SAT) ? SAT : v;
    endfunction

    // Reference: distinct lines in order of first active lane.
    task automatic build_expect(input logic [LANES-1:0] mask);
        exp_n = 0;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                logic [ADDR_W-1:0] l;
                bit seen;
                l = addr_a[i] & ~ADDR_W'(LINE_BYTES - 1);
                seen = 0;
                for (int k = 0; k < exp_n; k++) if (exp_l[k] == l) seen = 1;
                if (!seen) begin
                    exp_l[exp_n] = l;
                    exp_n++;
                end
            end
        end
    endtask

    task automatic run_instr(input logic [LANES-1:0] mask, input bit stream,
                             input bit junk_en, input int rdy_pct);
        int idx;
        bit prev_last, prev_gap, ok_end;
        build_expect(mask);
        @(negedge clk);
        stream_mode = stream;
        in_mask = mask;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        m_instr = sat(m_instr + 1);
        m_lines = sat(m_lines + exp_n);
        m_unc = sat(m_unc + ((exp_n > 1) ? 1 : 0));
        chk(line_count == CW'(exp_n), "R7 line_count", line_count, exp_n);
        chk(uncoalesced == (exp_n > 1), "R7 uncoalesced", uncoalesced, exp_n > 1);
        idx = 0;
        prev_last = (exp_n == 0);
        prev_gap = 0;
        ok_end = 0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            bit rdy, hs;
            if (prev_last) begin
                chk(done == 1'b1, (exp_n == 0) ? "R2 empty done" : "R6 done pulse", done, 1);
                chk(busy == 1'b0, "R5 busy low at end", busy, 0);
                chk(req_valid == 1'b0, "R2 no request at end", req_valid, 0);
                chk(stat_instr == CNT_W'(m_instr), "R10 stat_instr", stat_instr, m_instr);
                chk(stat_lines == CNT_W'(m_lines), "R10 stat_lines", stat_lines, m_lines);
                chk(stat_uncoal == CNT_W'(m_unc), "R10 stat_uncoal", stat_uncoal, m_unc);
                ok_end = 1;
                break;
            end
            chk(done == 1'b0, "R6 no early done", done, 0);
            chk(busy == 1'b1, "R5 busy while issuing", busy, 1);
            if (prev_gap)
                chk(req_valid == 1'b0, "R8 penalty gap", req_valid, 0);
            else
                chk(req_valid == 1'b1, stream ? "R9 back to back" : "R4 valid held", req_valid, 1);
            if (req_valid)
                chk(req_line == exp_l[idx], "R3 line order/R1 line value", req_line, exp_l[idx]);
            rdy = ($urandom % 100) < rdy_pct;
            req_ready = rdy;
            hs = req_valid && rdy;
            if (junk_en && !(hs && idx + 1 == exp_n) && ($urandom % 3 == 0)) begin
                in_valid = 1'b1;
                in_mask = $urandom;
            end else begin
                in_valid = 1'b0;
            end
            prev_gap = hs && (idx + 1 < exp_n) && !stream;
            prev_last = hs && (idx + 1 == exp_n);
            if (hs) idx++;
            @(negedge clk);
        end
        req_ready = 1'b0;
        in_valid = 1'b0;
        if (!ok_end) chk(1'b0, "R6 instruction never completed", idx, exp_n);
    endtask

    task automatic gen_random();
        logic [ADDR_W-OFF_W-1:0] bases [6];
        int k;
        k = 1 + ($urandom % 6);
        for (int b = 0; b < 6; b++) bases[b] = $urandom;
        for (int i = 0; i < LANES; i++) begin
            if ($urandom % 8 == 0)
                addr_a[i] = $urandom;
            else
                addr_a[i] = {bases[$urandom % k], OFF_W'($urandom)};
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !finished) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LANES; i++) addr_a[i] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state.
        chk(busy == 0 && req_valid == 0 && done == 0, "R11 reset handshake", {busy, req_valid, done}, 0);
        chk(line_count == 0 && uncoalesced == 0, "R11 reset report", line_count, 0);
        chk(stat_instr == 0 && stat_lines == 0 && stat_uncoal == 0, "R11 reset counters", stat_lines, 0);
        rst_n = 1'b1;

        // R2: empty mask.
        run_instr('0, 1'b0, 1'b0, 100);
        // R1: all lanes in one line, different offsets.
        for (int i = 0; i < LANES; i++) addr_a[i] = 32'h0004_1200 + ADDR_W'(i * 3);
        run_instr('1, 1'b0, 1'b0, 100);
        // R8: every lane a distinct line, penalty mode, full readiness.
        for (int i = 0; i < LANES; i++) addr_a[i] = 32'h0010_0000 + ADDR_W'(i * LINE_BYTES) + 5;
        run_instr('1, 1'b0, 1'b0, 100);
        // R9: same, stream mode.
        run_instr('1, 1'b1, 1'b0, 100);
        // R3: lane order beats address order; R2: inactive lane 3 excluded.
        addr_a[0] = 32'h0000_9010;
        addr_a[1] = 32'h0000_0140;
        addr_a[2] = 32'h0000_907f;
        addr_a[3] = 32'h0000_5000;
        run_instr(32'h0000_0007, 1'b0, 1'b0, 100);
        // R4/R5: back-pressure plus junk offers while busy.
        run_instr(32'h0000_0007, 1'b1, 1'b1, 30);
        // Single active lane at the top.
        addr_a[31] = 32'hdead_beef;
        run_instr(32'h8000_0000, 1'b0, 1'b1, 50);

        for (int t = 0; t < 260; t++) begin
            logic [LANES-1:0] m;
            gen_random();
            case ($urandom % 4)
                0: m = '1;
                1: m = $urandom;
                2: m = $urandom & $urandom & $urandom;
                default: m = ($urandom % 10 == 0) ? '0 : $urandom | $urandom;
            endcase
            run_instr(m, $urandom % 2, $urandom % 2, 20 + ($urandom % 81));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule